// File: doc/BRIEF.md
# PLL and Divider Rate Calculator

This block works out clock frequencies from the raw contents of clock-control setting words. It holds four PLL setting words, four spread-spectrum words, a reference frequency in kHz and one divider word. When `start_i` is accepted, it latches all of these inputs. The low bits of the divider word pick one of the four PLLs. The block decodes that PLL's pre-divider, multiplier and post-shift, and adds a fractional correction for the two upper PLLs. It then passes the resulting PLL rate through four cascaded integer dividers.

Every division runs through one shared restoring divider that produces one quotient bit per cycle. A computation always takes the same number of cycles, whatever the operand values are. When it ends, a one-cycle `done_o` pulse appears. The PLL rate and the four divided rates are then held on the outputs until the next computation finishes. A zero pre-divider or an out-of-range PLL selection is reported on `err_o`, and every rate is then forced to zero.

Top module: `pll_rate_calc`

## Requirements
- R1: While reset is asserted and after its release, `busy_o`, `done_o` and `err_o` are 0 and every rate output is 0.
- R2: In the selected PLL word, P is bits 23:18, M is bits 17:8 and S is bits 7:0. The integer rate is ((M × ref) / P) >> S, multiplied by 1000 and kept modulo 2^RATE_W.
- R3: The fractional term uses K from bits 31:16 of the selected spread-spectrum word. The term is ((((K × 1000) >> 16) × ref) / P) >> S. It is added to the integer rate only when the selected PLL index is 2 or 3 and K is non-zero.
- R4: Bits 2:0 of the divider word select the PLL, with values 0 to 3 valid. A value from 4 to 7 sets `err_o` and gives zero rates.
- R5: Four 6-bit divider fields sit at bits 8:3, 14:9, 20:15 and 26:21, and each field's ratio is its value plus one. Level 0 is the PLL rate divided by ratio 0. Each later level is the previous level divided by its own ratio, with truncating division.
- R6: A P field of 0 sets `err_o`, and the PLL rate and all four level rates are 0.
- R7: `start_i` is accepted on a rising edge where `busy_o` is 0. `busy_o` then stays high, and `done_o` pulses for exactly one cycle on the 6×RATE_W-th rising edge after the accepting edge, at which point `busy_o` falls.
- R8: A `start_i` that arrives while `busy_o` is high is ignored. Input changes after the accepting edge do not affect the running result.
- R9: The rate outputs and `err_o` change only on the edge that raises `done_o`, and they hold their values between completions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request a computation |
| pll_cfg_i | input | 4×32 | PLL setting words, index 0 to 3 |
| ssc_cfg_i | input | 4×32 | Spread-spectrum words carrying K |
| ref_khz_i | input | REF_W | Reference frequency in kHz |
| div_cfg_i | input | 32 | PLL select and four divider fields |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero pre-divider or invalid PLL select |
| pll_rate_o | output | RATE_W | Selected PLL rate |
| lvl_rate_o | output | 4×RATE_W | Rate after each divider level, level 0 in the low slice |

## Verification
The bench targets the fractional gate. It uses the same non-zero K on PLL 1 and on PLL 2, and a zero K on PLL 3. A design that tested the index wrongly, or ignored K being zero, would then add or drop the correction and be off by the fractional amount.

It also covers divider fields at their extremes (ratio 1 and ratio 64), S shifts large enough to empty the quotient, a zero P and select codes 4 to 7. A design that lost the plus-one, misplaced a field or let the divide-by-zero quotient through would output the wrong cascade or all-ones rates.

Start pulses and input changes are applied mid-run, and outputs are watched after completion. These expose a machine that restarts or leaks new inputs into a running result.

// File: rtl/pll_rate_calc.sv
module pll_rate_calc #(
  parameter int REF_W  = 20,
  parameter int RATE_W = 32
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [3:0][31:0]            pll_cfg_i,
  input  logic [3:0][31:0]            ssc_cfg_i,
  input  logic [REF_W-1:0]            ref_khz_i,
  input  logic [31:0]                 div_cfg_i,
  output logic                        busy_o,
  output logic                        done_o,
  output logic                        err_o,
  output logic [RATE_W-1:0]           pll_rate_o,
  output logic [3:0][RATE_W-1:0]      lvl_rate_o
);
  localparam int W    = RATE_W;
  localparam int CW   = $clog2(W);
  localparam int LAT  = 6 * W;
  localparam int LW   = $clog2(LAT + 1) + 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [31:0]      pll_q, ssc_q, div_q;
  logic [REF_W-1:0] ref_q;
  logic [2:0]       ph_q;
  logic [CW-1:0]    cnt_q;
  logic [W:0]       rem_q;
  logic [W-1:0]     quo_q, dvs_q, int_q, pll_hold_q;
  logic [2:0][W-1:0] lvl_hold_q;

  // operands taken straight from the inputs for the first division
  logic [31:0]  in_pw;
  logic [W-1:0] in_m, in_p, in_ref, in_dividend;
  assign in_pw       = pll_cfg_i[div_cfg_i[1:0]];
  assign in_m        = W'(in_pw[17:8]);
  assign in_p        = W'(in_pw[23:18]);
  assign in_ref      = W'(ref_khz_i);
  assign in_dividend = in_m * in_ref;

  // decoded fields of the latched operands
  logic [2:0]  sel;
  logic [5:0]  p_f;
  logic [7:0]  s_f;
  logic [15:0] k_f;
  logic [25:0] k_scaled;
  logic [W-1:0] k_frac, ref_w, frac_dividend;
  logic bad;
  assign sel           = div_q[2:0];
  assign p_f           = pll_q[23:18];
  assign s_f           = pll_q[7:0];
  assign k_f           = ssc_q[31:16];
  assign k_scaled      = 26'(k_f) * 26'd1000;
  assign k_frac        = W'(k_scaled[25:16]);
  assign ref_w         = W'(ref_q);
  assign frac_dividend = k_frac * ref_w;
  assign bad           = (p_f == 6'd0) || sel[2];

  // one restoring step
  logic [W:0]   rem_sh, rem_nx;
  logic         ge;
  logic [W-1:0] q_nx;
  assign rem_sh = {rem_q[W-1:0], quo_q[W-1]};
  assign ge     = rem_sh >= {1'b0, dvs_q};
  assign rem_nx = ge ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
  assign q_nx   = {quo_q[W-2:0], ge};

  // PLL rate once both quotients are known (used in phase 1)
  logic [W-1:0] int_scaled, frac_term, pll_res;
  logic         use_frac;
  assign int_scaled = (int_q >> s_f) * W'(1000);
  assign frac_term  = q_nx >> s_f;
  assign use_frac   = (sel == 3'd2 || sel == 3'd3) && (k_f != 16'd0);
  assign pll_res    = bad ? '0 : int_scaled + (use_frac ? frac_term : '0);

  function automatic logic [W-1:0] ratio_of(input logic [31:0] d, input logic [1:0] i);
    ratio_of = W'(d[3 + 6*int'(i) +: 6]) + W'(1);
  endfunction

  logic [2:0] ph_m1, ph_m2;
  assign ph_m1 = ph_q - 3'd1;
  assign ph_m2 = ph_q - 3'd2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pll_q <= '0; ssc_q <= '0; div_q <= '0; ref_q <= '0;
      ph_q <= '0; cnt_q <= '0; rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      int_q <= '0; pll_hold_q <= '0; lvl_hold_q <= '0;
      busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
      pll_rate_o <= '0; lvl_rate_o <= '0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          pll_q <= in_pw;
          ssc_q <= ssc_cfg_i[div_cfg_i[1:0]];
          div_q <= div_cfg_i;
          ref_q <= ref_khz_i;
          quo_q <= in_dividend;
          dvs_q <= in_p;
          rem_q <= '0;
          cnt_q <= '0;
          ph_q  <= '0;
          busy_o <= 1'b1;
        end
      end else if (cnt_q != LAST) begin
        rem_q <= rem_nx;
        quo_q <= q_nx;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        rem_q <= '0;
        cnt_q <= '0;
        ph_q  <= ph_q + 3'd1;
        case (ph_q)
          3'd0: begin
            int_q <= q_nx;
            quo_q <= frac_dividend;
            dvs_q <= W'(p_f);
          end
          3'd1: begin
            pll_hold_q <= pll_res;
            quo_q <= pll_res;
            dvs_q <= ratio_of(div_q, 2'd0);
          end
          3'd5: begin
            pll_rate_o <= pll_hold_q;
            lvl_rate_o <= {q_nx, lvl_hold_q[2], lvl_hold_q[1], lvl_hold_q[0]};
            err_o  <= bad;
            done_o <= 1'b1;
            busy_o <= 1'b0;
          end
          default: begin
            lvl_hold_q[ph_m2[1:0]] <= q_nx;
            quo_q <= q_nx;
            dvs_q <= ratio_of(div_q, ph_m1[1:0]);
          end
        endcase
      end
    end
  end

  // cycle counter used only to check the completion window
  logic [LW-1:0] lat_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               lat_q <= '0;
    else if (!busy_o && start_i) lat_q <= '0;
    else if (busy_o)           lat_q <= lat_q + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk_i) !rst_ni |=> !busy_o && !done_o && !err_o);
  p_start_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o |=> busy_o);
  p_done_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lat_q == LW'(LAT)) && !busy_o);
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_latched_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(div_q) && $stable(pll_q) && $stable(ref_q));
  p_err_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> pll_rate_o == '0 && lvl_rate_o == '0);
  p_cascade_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lvl_rate_o[0] <= pll_rate_o && lvl_rate_o[1] <= lvl_rate_o[0]
               && lvl_rate_o[2] <= lvl_rate_o[1] && lvl_rate_o[3] <= lvl_rate_o[2]);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(pll_rate_o) && $stable(lvl_rate_o) && $stable(err_o));
endmodule

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;
  localparam int PERIOD = 10;
  localparam int REF_W  = 20;
  localparam int LAT    = 6 * 32;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [3:0][31:0] pw, sw;
  logic [REF_W-1:0] rf;
  logic [31:0] dw;
  logic busy, done, err;
  logic [31:0] prate;
  logic [3:0][31:0] lrate;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  pll_rate_calc #(.REF_W(REF_W), .RATE_W(32)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pll_cfg_i(pw), .ssc_cfg_i(sw),
    .ref_khz_i(rf), .div_cfg_i(dw), .busy_o(busy), .done_o(done), .err_o(err),
    .pll_rate_o(prate), .lvl_rate_o(lrate));

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void model(input logic [3:0][31:0] p, input logic [3:0][31:0] s,
      input logic [REF_W-1:0] r, input logic [31:0] d,
      output logic [31:0] pr, output logic [3:0][31:0] lr, output logic e);
    logic [2:0] sl; logic [31:0] w, k; longint m, pp, sh, iq, kf, fq, acc;
    sl = d[2:0]; w = p[sl[1:0]]; k = 32'(s[sl[1:0]][31:16]);
    m = longint'(w[17:8]); pp = longint'(w[23:18]); sh = longint'(w[7:0]);
    e = (pp == 0) || (sl > 3);
    lr = '0; pr = '0;
    if (e) return;
    iq = (m * longint'(r)) / pp;
    acc = (sh >= 63) ? 0 : ((iq >> sh) * 1000);
    kf = (k * 1000) >> 16;
    fq = (kf * longint'(r)) / pp;
    if ((sl == 2 || sl == 3) && k != 0) acc = acc + ((sh >= 63) ? 0 : (fq >> sh));
    pr = 32'(acc);
    acc = longint'(pr);
    for (int i = 0; i < 4; i++) begin
      acc = acc / (longint'(d[3 + 6*i +: 6]) + 1);
      lr[i] = 32'(acc);
    end
  endfunction

  // run one computation; checks latency, busy and results
  task automatic run(input string tag);
    logic [31:0] epr; logic [3:0][31:0] elr; logic ee; int cnt;
    model(pw, sw, rf, dw, epr, elr, ee);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    check({tag, " R7 busy"}, busy, 1);
    while (!done && cnt < 1000) begin
      @(negedge clk);
      cnt++;
    end
    check({tag, " R7 latency"}, cnt, LAT);
    check({tag, " R7 busy low"}, busy, 0);
    check({tag, " R6/R4 err"}, err, ee);
    check({tag, " R2/R3 pll"}, prate, epr);
    for (int i = 0; i < 4; i++) check({tag, " R5 level"}, lrate[i], elr[i]);
    @(negedge clk);
    check({tag, " R7 pulse"}, done, 0);
  endtask

  function automatic logic [31:0] pword(input int p, input int m, input int s);
    pword = (32'(p) << 18) | (32'(m) << 8) | 32'(s);
  endfunction
  function automatic logic [31:0] dword(input int sl, input int a, input int b, input int c, input int d);
    dword = 32'(sl) | (32'(a) << 3) | (32'(b) << 9) | (32'(c) << 15) | (32'(d) << 21);
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] hp; logic [3:0][31:0] hl; logic he;
    void'($urandom(32'd4242));
    pw = '0; sw = '0; rf = '0; dw = '0;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0); check("R1 done", done, 0);
    check("R1 err", err, 0); check("R1 rate", prate, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {busy, done, err}, 0);
    check("R1 level", lrate, 0);

    // R2 plain integer rate
    pw[0] = pword(3, 200, 1); rf = 24000; dw = dword(0, 0, 1, 2, 3);
    run("R2 direct");
    check("R2 value", prate, 800000000);

    // R3 fractional only on PLL 2/3 with K != 0
    pw[1] = pword(2, 100, 0); pw[2] = pword(2, 100, 0); pw[3] = pword(2, 100, 0);
    sw[1] = 32'h8000_0000; sw[2] = 32'h8000_0000; sw[3] = 32'h0000_FFFF;
    rf = 1000;
    dw = dword(1, 0, 0, 0, 0); run("R3 pll1");
    check("R3 no frac pll1", prate, 50000000);
    dw = dword(2, 0, 0, 0, 0); run("R3 pll2");
    check("R3 frac pll2", prate, 50000000 + 250000);
    dw = dword(3, 0, 0, 0, 0); run("R3 pll3 k0");
    check("R3 k zero", prate, 50000000);

    // R4 invalid selects
    for (int s = 4; s < 8; s++) begin
      dw = dword(s, 1, 1, 1, 1); run("R4 bad sel");
      check("R4 err set", err, 1);
    end

    // R5 ratio extremes
    pw[0] = pword(1, 1023, 0); rf = 20'hFFFFF;
    dw = dword(0, 63, 0, 63, 0); run("R5 extremes");
    dw = dword(0, 5, 62, 1, 17); run("R5 mixed");

    // R6 zero P
    pw[2] = pword(0, 500, 0); sw[2] = 32'h1234_0000; dw = dword(2, 1, 1, 1, 1);
    run("R6 p zero");
    check("R6 err", err, 1);

    // S large enough to empty quotient
    pw[3] = pword(5, 900, 200); sw[3] = 32'hFFFF_0000; dw = dword(3, 0, 0, 0, 0);
    run("R2 big shift");
    check("R2 big shift zero", prate, 0);

    // R8 start and input changes while busy
    pw[0] = pword(7, 333, 2); rf = 50000; dw = dword(0, 3, 2, 1, 0);
    model(pw, sw, rf, dw, hp, hl, he);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    pw[0] = pword(1, 1, 0); rf = 7; dw = dword(1, 9, 9, 9, 9);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R8 still busy", busy, 1);
    while (!done) @(negedge clk);
    check("R8 pll kept", prate, hp);
    check("R8 level kept", lrate[3], hl[3]);

    // R9 hold after completion
    repeat (30) @(negedge clk);
    pw = '1; dw = dword(0, 0, 0, 0, 0);
    repeat (30) @(negedge clk);
    check("R9 hold pll", prate, hp);
    check("R9 hold level", lrate[0], hl[0]);
    check("R9 hold err", err, 0);

    // random
    for (int n = 0; n < 40; n++) begin
      for (int i = 0; i < 4; i++) begin
        pw[i] = pword(($urandom % 8 == 0) ? 0 : 1 + $urandom % 63,
                      $urandom % 1024, ($urandom % 10 == 0) ? $urandom % 256 : $urandom % 5);
        sw[i] = ($urandom % 3 == 0) ? 32'h0 : $urandom;
      end
      rf = REF_W'($urandom);
      dw = $urandom;
      if ($urandom % 4 != 0) dw[2] = 1'b0;
      run("R5 random");
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule